// File: doc/BRIEF.md
# UART Interrupt Prioritizer and Identification Register

This block sits beside a FIFO-equipped UART and decides which interrupt the host sees. It takes raw requests from the receiver, the transmitter and the modem-control logic. It masks each request with a six-bit enable register and sorts the survivors into four priority levels. It drives a single interrupt line and presents the winning source through a read-only identification register.

The identification register shares its bus offset with the write-only FIFO control register: reads at that offset return the identification, and writes at it update the FIFO enable. One enable bit changes meaning with the mode. In normal mode it gates line status requests. In infrared mode it gates link status requests while receiving and underrun requests while transmitting.

A read strobe may stay high for several cycles. During that time the identification value on the bus does not change. The request inputs keep being sampled, and the display catches up once the strobe drops. A transmitter-empty source is latched at the moment the shift register and the transmit FIFO are both empty. It is cleared by a completed read that showed it.

Top module: `uart_irq_id`

## Requirements
- R1: After reset the enable register reads 00h at offset 1, the identification register reads 01h at offset 2, and `irq` is 0.
- R2: Enable bits 5:0 are writable at offset 1. Bits 7:6 are reserved and always read 0, so writing FFh reads back 3Fh.
- R3: Identification bits 2:1 give the highest enabled pending level. The codes, from highest to lowest priority, are: status 11 (enable bit 2), receive data or timeout 10 (bit 0), transmit low-level or transmitter-empty 01 (bits 1 and 5), modem 00 (bit 3).
- R4: Enable bit 2 gates `stat_req` in normal mode (`mode_ir`=0) and in infrared receive (`mode_ir`=1, `ir_tx_dir`=0). In infrared transmit it gates `txur_req` instead and ignores `stat_req`. Outside infrared transmit, `txur_req` has no effect.
- R5: When `tx_shift_empty` and `tx_fifo_empty` first become 1 together, a transmitter-empty request is latched. It shows as code 01 only when enable bit 5 is set. One of the two empty inputs alone latches nothing.
- R6: A completed read at offset 2 that displayed pending code 01 while the transmitter-empty request was latched clears that request.
- R7: Bit 3 is 1 only when FIFOs are enabled, `rx_tmo_req` is active and the receive level is the winner. With FIFOs disabled, `rx_tmo_req` raises no request.
- R8: Identification bits 7:6 both equal the FIFO enable (bit 0 written at offset 2), and bits 5:4 read 0. Writes at offset 2 leave the enable register unchanged.
- R9: While `rd_en` stays high at offset 2, `rdata` holds the value shown on the strobe's first cycle. Requests arriving meanwhile still drive `irq` and appear on the next read.
- R10: `irq` is 1 exactly when some enabled request is pending.
- R11: When bit 0 is 1 (nothing pending), bits 3:1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe, may span several cycles |
| rdata | output | 8 | Read data, 0 when not reading a mapped offset |
| mode_ir | input | 1 | 1 selects infrared mode |
| ir_tx_dir | input | 1 | In infrared mode, 1 means transmitting |
| stat_req | input | 1 | Line or link status request (level) |
| txur_req | input | 1 | Transmit FIFO underrun request (level) |
| rx_data_req | input | 1 | Receive data available request (level) |
| rx_tmo_req | input | 1 | Receive read timeout request (level) |
| tx_low_req | input | 1 | Transmit FIFO low-level request (level) |
| modem_req | input | 1 | Modem status request (level) |
| tx_shift_empty | input | 1 | Transmit shift register empty |
| tx_fifo_empty | input | 1 | Transmit FIFO empty |
| irq | output | 1 | Interrupt output |

## Verification
Level requests and enable writes reach `irq` in the same cycle. They reach the displayed identification at the next clock edge. A transmitter-empty event takes one more edge because it is latched first. The bench changes inputs on falling edges and waits two full cycles before starting a read, which covers both latencies. Each read raises the strobe on a falling edge and samples `rdata` one cycle later, after a rising edge has passed with the display frozen. The bench then idles two cycles so that the post-read clear of the transmitter-empty request has settled before the next read.

// File: rtl/uart_irq_id.sv
module uart_irq_id #(
  parameter int AW = 3,
  parameter logic [AW-1:0] IEN_OFS = 3'd1,
  parameter logic [AW-1:0] ID_OFS  = 3'd2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [7:0]    wdata,
  input  logic          rd_en,
  output logic [7:0]    rdata,
  input  logic          mode_ir,
  input  logic          ir_tx_dir,
  input  logic          stat_req,
  input  logic          txur_req,
  input  logic          rx_data_req,
  input  logic          rx_tmo_req,
  input  logic          tx_low_req,
  input  logic          modem_req,
  input  logic          tx_shift_empty,
  input  logic          tx_fifo_empty,
  output logic          irq
);

  logic [5:0] ier_q;
  logic       fifo_en_q;
  logic       txe_pend;
  logic       empty_q;
  logic       rd_id_q;
  logic [7:0] id_q;

  logic       rd_id;
  logic       both_empty;
  logic       lvl_stat, lvl_rx, lvl_tx, lvl_ms;
  logic       pend;
  logic [1:0] code;
  logic       tmo_flag;
  logic [7:0] id_live;

  assign rd_id      = rd_en && (addr == ID_OFS);
  assign both_empty = tx_shift_empty && tx_fifo_empty;

  assign lvl_stat = ier_q[2] && ((mode_ir && ir_tx_dir) ? txur_req : stat_req);
  assign lvl_rx   = ier_q[0] && (rx_data_req || (fifo_en_q && rx_tmo_req));
  assign lvl_tx   = (ier_q[1] && tx_low_req) || (ier_q[5] && txe_pend);
  assign lvl_ms   = ier_q[3] && modem_req;

  always_comb begin
    pend     = 1'b1;
    code     = 2'b00;
    tmo_flag = 1'b0;
    if (lvl_stat)      code = 2'b11;
    else if (lvl_rx) begin
      code     = 2'b10;
      tmo_flag = fifo_en_q && rx_tmo_req;
    end
    else if (lvl_tx)   code = 2'b01;
    else if (lvl_ms)   code = 2'b00;
    else               pend = 1'b0;
  end

  assign id_live = {{2{fifo_en_q}}, 2'b00, tmo_flag, code, ~pend};
  assign irq     = pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ier_q     <= '0;
      fifo_en_q <= 1'b0;
    end else if (wr_en) begin
      if (addr == IEN_OFS) ier_q     <= wdata[5:0];
      if (addr == ID_OFS)  fifo_en_q <= wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      empty_q  <= 1'b1;
      txe_pend <= 1'b0;
      rd_id_q  <= 1'b0;
      id_q     <= 8'h01;
    end else begin
      empty_q <= both_empty;
      rd_id_q <= rd_id;
      if (both_empty && !empty_q)
        txe_pend <= 1'b1;
      else if (!both_empty)
        txe_pend <= 1'b0;
      else if (rd_id_q && !rd_id && !id_q[0] && id_q[2:1] == 2'b01)
        txe_pend <= 1'b0;
      if (!rd_id)
        id_q <= id_live;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (rd_en) begin
      if (addr == IEN_OFS)     rdata = {2'b00, ier_q};
      else if (addr == ID_OFS) rdata = id_q;
    end
  end

endmodule

// File: rtl/uart_irq_id_chk.sv
module uart_irq_id_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] addr,
  input logic       rd_en,
  input logic [7:0] rdata,
  input logic       irq,
  input logic [5:0] ier_q
);

  logic rd_id;
  assign rd_id = rd_en && (addr == 3'd2);

  a_r9_frozen_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_id && $past(rd_id)) |-> $stable(rdata));

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd1) |-> (rdata[7:6] == 2'b00));

  a_r8_fen_pair: assert property (@(posedge clk) disable iff (!rst_n)
    rd_id |-> (rdata[7] == rdata[6] && rdata[5:4] == 2'b00));

  a_r7_tmo_code: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_id && rdata[3]) |-> (rdata[2:0] == 3'b100));

  a_r11_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_id && rdata[0]) |-> (rdata[3:1] == 3'b000));

  a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_q == 6'd0) |-> !irq);

endmodule

bind uart_irq_id uart_irq_id_chk chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en),
  .rdata(rdata), .irq(irq), .ier_q(ier_q)
);

// File: tb/uart_irq_id_tb_top.sv
module uart_irq_id_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic mode_ir = 0, ir_tx_dir = 0;
  logic stat_req = 0, txur_req = 0, rx_data_req = 0, rx_tmo_req = 0, tx_low_req = 0, modem_req = 0;
  logic tx_shift_empty = 0, tx_fifo_empty = 0;
  logic irq;

  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  uart_irq_id dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .mode_ir(mode_ir), .ir_tx_dir(ir_tx_dir),
    .stat_req(stat_req), .txur_req(txur_req), .rx_data_req(rx_data_req),
    .rx_tmo_req(rx_tmo_req), .tx_low_req(tx_low_req), .modem_req(modem_req),
    .tx_shift_empty(tx_shift_empty), .tx_fifo_empty(tx_fifo_empty), .irq(irq)
  );

  // {ier[7:0], fifo, ir, txdir, reqs{stat,txur,rxd,rxt,txlow,modem}, expected id}
  localparam logic [24:0] VEC [16] = '{
    {8'h0F, 1'b0, 1'b0, 1'b0, 6'b101011, 8'h06},
    {8'h0F, 1'b0, 1'b0, 1'b0, 6'b001011, 8'h04},
    {8'h0F, 1'b0, 1'b0, 1'b0, 6'b000011, 8'h02},
    {8'h0F, 1'b0, 1'b0, 1'b0, 6'b000001, 8'h00},
    {8'h0F, 1'b0, 1'b0, 1'b0, 6'b000000, 8'h01},
    {8'h0B, 1'b0, 1'b0, 1'b0, 6'b100001, 8'h00},
    {8'h0F, 1'b1, 1'b0, 1'b0, 6'b000100, 8'hCC},
    {8'h0F, 1'b0, 1'b0, 1'b0, 6'b000100, 8'h01},
    {8'h0F, 1'b1, 1'b0, 1'b0, 6'b001000, 8'hC4},
    {8'h0F, 1'b1, 1'b0, 1'b0, 6'b001100, 8'hCC},
    {8'h04, 1'b0, 1'b1, 1'b0, 6'b100000, 8'h06},
    {8'h04, 1'b0, 1'b1, 1'b1, 6'b100000, 8'h01},
    {8'h04, 1'b0, 1'b1, 1'b1, 6'b010000, 8'h06},
    {8'h04, 1'b0, 1'b0, 1'b0, 6'b010000, 8'h01},
    {8'h00, 1'b1, 1'b0, 1'b0, 6'b111111, 8'hC1},
    {8'h0E, 1'b1, 1'b0, 1'b0, 6'b001010, 8'hC2}
  };
  localparam string TAG [16] = '{"R3", "R3", "R3", "R3", "R11", "R3", "R7", "R7",
                                 "R7", "R7", "R4", "R4", "R4", "R4", "R10", "R3"};

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    v = rdata;
    rd_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 20000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(3'd1, v); check("R1", v, 8'h00);
    rd(3'd2, v); check("R1", v, 8'h01);
    check("R1", {7'd0, irq}, 8'h00);

    // R2 reserved bits
    wr(3'd1, 8'hFF);
    rd(3'd1, v); check("R2", v, 8'h3F);

    // R8 write at offset 2 leaves enables alone
    wr(3'd2, 8'h01);
    rd(3'd1, v); check("R8", v, 8'h3F);
    rd(3'd2, v); check("R8", v, 8'hC1);
    wr(3'd2, 8'h00);

    for (int i = 0; i < 16; i++) begin
      wr(3'd1, VEC[i][24:17]);
      wr(3'd2, {7'd0, VEC[i][16]});
      mode_ir = VEC[i][15]; ir_tx_dir = VEC[i][14];
      {stat_req, txur_req, rx_data_req, rx_tmo_req, tx_low_req, modem_req} = VEC[i][13:8];
      settle();
      rd(3'd2, v); check(TAG[i], v, VEC[i][7:0]);
      check("R10", {7'd0, irq}, {7'd0, ~VEC[i][0]});
    end
    mode_ir = 0; ir_tx_dir = 0;
    {stat_req, txur_req, rx_data_req, rx_tmo_req, tx_low_req, modem_req} = '0;
    wr(3'd2, 8'h00);

    // R9 frozen display during a long read
    wr(3'd1, 8'h0F);
    modem_req = 1'b1;
    settle();
    addr = 3'd2; rd_en = 1'b1;
    @(negedge clk);
    check("R9", rdata, 8'h00);
    stat_req = 1'b1;
    repeat (3) @(negedge clk);
    check("R9", rdata, 8'h00);
    check("R9", {7'd0, irq}, 8'h01);
    rd_en = 1'b0;
    settle();
    rd(3'd2, v); check("R9", v, 8'h06);
    stat_req = 1'b0; modem_req = 1'b0;

    // R5 transmitter-empty latch, enabled
    wr(3'd1, 8'h20);
    tx_fifo_empty = 1'b1;
    settle();
    rd(3'd2, v); check("R5", v, 8'h01);
    tx_shift_empty = 1'b1;
    settle();
    check("R5", {7'd0, irq}, 8'h01);
    rd(3'd2, v); check("R5", v, 8'h02);
    // R6 cleared by the read that showed it
    rd(3'd2, v); check("R6", v, 8'h01);
    check("R6", {7'd0, irq}, 8'h00);

    // R5 masked when bit 5 off
    tx_shift_empty = 1'b0; tx_fifo_empty = 1'b0;
    wr(3'd1, 8'h00);
    settle();
    tx_shift_empty = 1'b1; tx_fifo_empty = 1'b1;
    settle();
    rd(3'd2, v); check("R5", v, 8'h01);
    wr(3'd1, 8'h20);
    settle();
    rd(3'd2, v); check("R5", v, 8'h02);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule